// File: doc/BRIEF.md
# Interrupt and Power-Down Pin Controller

This block drives one shared, active-low, open-drain pin of a PHY port and decides how that pin is used. After reset the pin is an input: pulling it low asks the port to power down. The request is the same as the power-down bit of the port's basic control register, which arrives here as `pd_ctl_bit`. Once software sets the output-enable bit in a small control register, the block stops listening to the pin and uses it as an interrupt request line instead. The power-down request then follows only `pd_ctl_bit`.

Event pulses from up to eight sources are caught in pending flags. Examples are a link-status change (source 5) and an energy-detect change (source 6). A combined status register holds these flags in its upper byte and a per-source enable mask in its lower byte. The pin is pulled low while the global interrupt enable and the output enable are both set and at least one masked source is pending or firing in the current cycle. This path contains no register, so an enabled event reaches the pin in the same cycle it arrives. A single read of the status register clears every pending flag at once, and the pin then lets go. An event that arrives together with the clearing read stays pending. The register port is a plain single-cycle read/write port with a one-bit register select. Framing of the management bus and the analog pad are outside this block.

Top module: `irqpd_pin_ctrl`

## Requirements
- R1: While and right after reset: the control word and the status word read 0, the pin is not an output, the pin is not pulled low, and `pd_req` equals `pd_ctl_bit`.
- R2: Select 0 addresses the control register. Bit 0 is the output enable and bit 1 is the global interrupt enable. Both bits can be written and read back, and all other bits read 0.
- R3: A write to the status register (select 1) loads the mask from data bits 7:0. Data bits 15:8 do not affect the pending flags, and a mask written without those bits reads back unchanged.
- R4: A one-cycle pulse on `src_evt[i]` sets pending bit i, which reads as status bit 8+i from the next cycle on. This happens whether or not mask bit i is set.
- R5: A status read returns the pending flags in bits 15:8 and the mask in bits 7:0, with no wait cycle. At the following clock edge it clears all pending flags.
- R6: A source whose event pulse coincides with a status read stays pending after that read.
- R7: `pin_drive_low` is 1 exactly when output enable and global enable are both 1 and some source with its mask bit set is either pending or pulsing in the same cycle. The path from `src_evt` to `pin_drive_low` has no clock delay.
- R8: With output enable 0, the pin is not driven. `pd_req` is 1 when `pd_ctl_bit` is 1 or when the pin level, seen through a two-stage synchronizer, is low. A pin change therefore shows on `pd_req` after the second rising edge.
- R9: With output enable 1, the pin level has no effect on `pd_req`, which equals `pd_ctl_bit`.
- R10: Writing 0x0003 to the control register and 0x0060 to the status register makes link-change events (source 5) and energy-detect events (source 6) pull the pin low, and leaves the other sources without effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the pending flags) |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, valid in the same cycle |
| src_evt | input | 8 | One-cycle event pulses, one bit per source |
| pd_ctl_bit | input | 1 | Power-down bit from the basic control register |
| pin_in | input | 1 | Sensed level of the shared pin |
| pin_oe | output | 1 | 1 while the pin is used as the interrupt output |
| pin_drive_low | output | 1 | 1 pulls the pin low (interrupt active) |
| pd_req | output | 1 | Power-down request to the port |

## Verification
The interrupt path is tested with a masked source, with sources that are enabled but lack the global enable or the output enable, and with the link and energy-detect pair enabled. This separates the mask from each of the two enable bits. Status reads are issued alone and together with fresh events, which shows whether clear-on-read drops an event that arrives in the same cycle. The pin is toggled both in input mode and in output mode, with and without the control-register power-down bit, so that the synchronizer delay and the ignoring of the pin in output mode can each be seen. A long stretch of random register accesses, events and pin levels is then compared against the reference model on every clock.

// File: rtl/irqpd_pkg.sv
package irqpd_pkg;
  localparam int REG_W      = 16;
  localparam int SRC_N      = REG_W / 2;
  localparam int CTL_OE_BIT = 0;
  localparam int CTL_IE_BIT = 1;
  localparam int SRC_LINK   = 5;
  localparam int SRC_ENERGY = 6;

  typedef enum logic {SEL_CTL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
  typedef logic [SRC_N-1:0] src_vec_t;
  typedef struct packed {
    logic ie;
    logic oe;
  } ctl_t;

  // next pending value: a clear empties the flags, new events always land
  function automatic src_vec_t pend_update(src_vec_t cur, src_vec_t evt, logic clr);
    return (clr ? '0 : cur) | evt;
  endfunction

  // any enabled source active now (latched or arriving)
  function automatic logic irq_hit(src_vec_t pend, src_vec_t evt, src_vec_t mask);
    return |((pend | evt) & mask);
  endfunction

  function automatic logic [REG_W-1:0] ctl_word(ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CTL_OE_BIT] = c.oe;
    w[CTL_IE_BIT] = c.ie;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] stat_word(src_vec_t pend, src_vec_t mask);
    return {pend, mask};
  endfunction
endpackage

// File: rtl/irqpd_sync.sv
module irqpd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqpd_regs.sv
module irqpd_regs
  import irqpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_wr,
  input  logic     stat_wr,
  input  logic     oe_wbit,
  input  logic     ie_wbit,
  input  src_vec_t mask_wdata,
  output ctl_t     ctl_q,
  output src_vec_t mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q.oe <= oe_wbit;
      ctl_q.ie <= ie_wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (stat_wr) mask_q <= mask_wdata;
  end
endmodule

// File: rtl/irqpd_pending.sv
module irqpd_pending
  import irqpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  logic     clr,
  output src_vec_t pend_q
);
  src_vec_t pend_d;

  always_comb pend_d = pend_update(pend_q, evt, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irqpd_pin_ctrl.sv
module irqpd_pin_ctrl
  import irqpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [SRC_N-1:0] src_evt,
  input  logic             pd_ctl_bit,
  input  logic             pin_in,
  output logic             pin_oe,
  output logic             pin_drive_low,
  output logic             pd_req
);
  // named internal events, visible to the bound checker
  logic     ctl_wr_ev, stat_wr_ev, stat_rd_ev;
  logic     pin_sync, pin_low_seen, irq_active;
  ctl_t     ctl_q;
  src_vec_t mask_q, pend_q;
  logic     wdata_hi_unused;

  assign ctl_wr_ev  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTL);
  assign stat_wr_ev = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
  assign stat_rd_ev = reg_rd && (reg_sel_e'(reg_sel) == SEL_STAT);
  assign wdata_hi_unused = &{1'b0, reg_wdata[REG_W-1:SRC_N]};

  irqpd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr_ev),
    .stat_wr    (stat_wr_ev),
    .oe_wbit    (reg_wdata[CTL_OE_BIT]),
    .ie_wbit    (reg_wdata[CTL_IE_BIT]),
    .mask_wdata (reg_wdata[SRC_N-1:0]),
    .ctl_q      (ctl_q),
    .mask_q     (mask_q)
  );

  irqpd_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (src_evt),
    .clr    (stat_rd_ev),
    .pend_q (pend_q)
  );

  irqpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_STAT) ? stat_word(pend_q, mask_q)
                                                       : ctl_word(ctl_q);

  assign irq_active    = ctl_q.ie && irq_hit(pend_q, src_evt, mask_q);
  assign pin_oe        = ctl_q.oe;
  assign pin_drive_low = ctl_q.oe && irq_active;
  assign pin_low_seen  = !ctl_q.oe && !pin_sync;
  assign pd_req        = pd_ctl_bit || pin_low_seen;
endmodule

// File: rtl/irqpd_pin_ctrl_chk.sv
module irqpd_pin_ctrl_chk
  import irqpd_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input src_vec_t evt,
  input logic     stat_rd,
  input logic     stat_wr,
  input src_vec_t pend,
  input src_vec_t mask,
  input logic     ie,
  input logic     pin_oe,
  input logic     pin_drive_low,
  input logic     pd_req,
  input logic     pd_bit
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> (!pin_oe && !pin_drive_low));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(mask));

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (pend == ($past(pend) | $past(evt))));

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == '0) |=> (pend == '0));

  p_keep_coincident_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (pend == $past(evt)));

  p_drive_needs_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_low |-> (pin_oe && ie && ((pend | evt) & mask) != '0));

  p_pin_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (pd_req == pd_bit));
endmodule

bind irqpd_pin_ctrl irqpd_pin_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt           (src_evt),
  .stat_rd       (stat_rd_ev),
  .stat_wr       (stat_wr_ev),
  .pend          (pend_q),
  .mask          (mask_q),
  .ie            (ctl_q.ie),
  .pin_oe        (pin_oe),
  .pin_drive_low (pin_drive_low),
  .pd_req        (pd_req),
  .pd_bit        (pd_ctl_bit)
);

// File: tb/irqpd_pin_ctrl_tb_top.sv
module irqpd_pin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  src_evt = '0;
  logic        pd_ctl_bit = 1'b0, pin_in = 1'b1;
  logic        pin_oe, pin_drive_low, pd_req;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit       m_oe, m_ie;
  bit [7:0] m_mask, m_pend;
  bit       pin_hist[$];

  always #5 clk = ~clk;

  irqpd_pin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .pd_ctl_bit(pd_ctl_bit), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_drive_low(pin_drive_low), .pd_req(pd_req)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_oe = 0; m_ie = 0; m_mask = '0; m_pend = '0;
    pin_hist = '{1'b1, 1'b1};
  endtask

  // compare every output against the model for the inputs now applied
  task automatic compare_all(string tag);
    bit [15:0] exp_rd;
    bit        exp_drv, exp_pd;
    if (reg_sel) exp_rd = {m_pend, m_mask};
    else         exp_rd = {14'd0, m_ie, m_oe};
    exp_drv = m_oe && m_ie && (((m_pend | src_evt) & m_mask) != 8'd0);
    exp_pd  = pd_ctl_bit || (!m_oe && !pin_hist[0]);
    check({tag, " rdata R2 R5"}, reg_rdata, exp_rd);
    check({tag, " drive R7"}, {15'd0, pin_drive_low}, {15'd0, exp_drv});
    check({tag, " oe R8"}, {15'd0, pin_oe}, {15'd0, m_oe});
    check({tag, " pd R8 R9"}, {15'd0, pd_req}, {15'd0, exp_pd});
  endtask

  task automatic step(string tag, bit wr, bit rd, bit sel, bit [15:0] wd,
                      bit [7:0] evt, bit pin, bit pdb);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    src_evt = evt; pin_in = pin; pd_ctl_bit = pdb;
    #2;
    compare_all(tag);
    @(posedge clk);
    #1;
    if (rd && sel) m_pend = evt;
    else           m_pend = m_pend | evt;
    if (wr && !sel) begin m_oe = wd[0]; m_ie = wd[1]; end
    if (wr && sel)  m_mask = wd[7:0];
    pin_hist.push_back(pin);
    void'(pin_hist.pop_front());
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    #12;
    compare_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step("R1 after reset", 0, 0, 0, 16'h0, 8'h00, 1, 0);
    step("R1 status after reset", 0, 1, 1, 16'h0, 8'h00, 1, 0);
    // R2: unused control bits read as 0
    step("R2 write ctl", 1, 0, 0, 16'hFFFC, 8'h00, 1, 0);
    step("R2 readback", 0, 1, 0, 16'h0, 8'h00, 1, 0);
    // R3: upper data byte does not touch pending
    step("R3 write mask", 1, 0, 1, 16'hFF60, 8'h00, 1, 0);
    step("R3 readback", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    // R4: masked source still latches
    step("R4 masked evt", 0, 0, 1, 16'h0, 8'h04, 1, 0);
    step("R4 pending seen", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    // R7: output enable alone, no global enable
    step("R7 oe only", 1, 0, 0, 16'h0001, 8'h00, 1, 0);
    step("R7 link evt no ie", 0, 0, 1, 16'h0, 8'h20, 1, 0);
    step("R5 read clears", 0, 1, 1, 16'h0, 8'h00, 1, 0);
    step("R5 after clear", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    // R10: the link / energy pair
    step("R10 ctl 0003", 1, 0, 0, 16'h0003, 8'h00, 1, 0);
    step("R10 stat 0060", 1, 0, 1, 16'h0060, 8'h00, 1, 0);
    step("R10 other src", 0, 0, 1, 16'h0, 8'h9F, 1, 0);
    step("R10 no drive", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    step("R5 clear other", 0, 1, 1, 16'h0, 8'h00, 1, 0);
    step("R10 link evt", 0, 0, 1, 16'h0, 8'h20, 1, 0);
    step("R10 link held", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    // R6: energy event arrives with the clearing read
    step("R6 read+energy", 0, 1, 1, 16'h0, 8'h40, 1, 0);
    step("R6 energy kept", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    step("R5 final clear", 0, 1, 1, 16'h0, 8'h00, 1, 0);
    step("R5 released", 0, 0, 1, 16'h0, 8'h00, 1, 0);
    // R9: pin ignored in output mode
    step("R9 pin low", 0, 0, 0, 16'h0, 8'h00, 0, 0);
    step("R9 pin low", 0, 0, 0, 16'h0, 8'h00, 0, 0);
    step("R9 pin low", 0, 0, 0, 16'h0, 8'h00, 0, 1);
    // R8: back to input mode, pin low reaches pd_req after two edges
    step("R8 to input", 1, 0, 0, 16'h0002, 8'h00, 1, 0);
    step("R8 pin low", 0, 0, 0, 16'h0, 8'h00, 0, 0);
    step("R8 sync 1", 0, 0, 0, 16'h0, 8'h00, 0, 0);
    step("R8 sync 2", 0, 0, 0, 16'h0, 8'h00, 1, 0);
    step("R8 release", 0, 0, 0, 16'h0, 8'h00, 1, 0);
    step("R8 released", 0, 0, 0, 16'h0, 8'h00, 1, 0);
    step("R8 ctl bit", 0, 0, 0, 16'h0, 8'h00, 1, 1);
    // mixed traffic compared on every clock
    for (int i = 0; i < 3000; i++) begin
      bit [3:0] r;
      r = 4'($urandom);
      step("rand", r[0] & r[1], r[2], r[3], 16'($urandom),
           8'($urandom) & 8'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule